// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Engine

This block is the serial front end of a byte-wide nonvolatile memory with 1024 locations, held here in an internal register array. An external SPI master selects it with an active-low chip select, shifts in an 8-bit command, a 16-bit address where one is needed, and then data. Data comes back on a serial output that is driven only while a read is in progress. All three serial inputs pass through synchronisers into the system clock. Edges of the serial clock are detected in that domain, so the system clock must run several times faster than the serial clock.

Writes land in a 32-byte page buffer. They are committed to the array only when chip select rises straight after a complete data byte, with the write-enable latch set and the external `wr_permit` decision high. A commit starts a program cycle that lasts `PROG_CYCLES` system clocks. During that cycle only the status read is honoured, and the status byte reads as all ones. When the cycle ends, the write-enable latch clears.

The controller is a state machine with these states:
- IDLE: chip select is high.
- OPC: receiving the command byte.
- ADDR: receiving the 16 address bits.
- READ: streaming array bytes.
- WRITE: collecting page data.
- STAT_RD: streaming the status byte.
- STAT_WR: collecting the status byte.
- SKIP: ignoring everything until the next select.

It moves between states as follows:
- A chip-select fall goes to OPC from any state.
- A chip-select rise goes to IDLE from any state.
- At the eighth command bit, OPC goes to ADDR, STAT_RD, STAT_WR or SKIP according to the command.
- At the sixteenth address bit, ADDR goes to READ or WRITE.

Top module: `spi_nvm_slave`

## Requirements
- R1: SPI modes 0 and 3 both work. SI is sampled on rising SCK, SO changes only after a falling SCK, and every field is sent MSB first.
- R2: The command is the first byte after CS falls. Bits 7..4 must be 0 and bit 3 is ignored. The low three bits select the command:
  - 110 sets the write-enable latch.
  - 100 clears the write-enable latch.
  - 101 reads the status byte.
  - 001 writes the status byte.
  - 011 reads the array.
  - 010 writes the array.
- R3: Any other command byte (including 0x00 and 0x07) has no effect. SO stays high-impedance (`so_oe`=0) and later SI bits are ignored until the next CS fall. SO is also high-impedance whenever no read is in progress.
- R4: The write-enable latch is 0 after reset. The 110 command sets it, the 100 command clears it, and the end of every program cycle clears it.
- R5: An array read takes a 16-bit address, of which only bits 9..0 are used. Bytes then stream out while the address increments, wrapping from 0x3FF to 0x000 for as long as CS stays low.
- R6: In an array write, each data byte goes to the next location. Only address bits 4..0 increment, so byte 33 of a transfer overwrites the first byte's location within the same 32-byte page.
- R7: A write commits only if all of the following hold:
  - CS rises directly after the eighth bit of a data byte.
  - At least one data byte was sent.
  - The write-enable latch is set.
  - `wr_permit` is 1.
  
  Otherwise the array, the status fields and the busy state are unchanged.
- R8: The status byte has bit 0 = busy, bit 1 = write-enable latch, bits 3..2 = protect level, bit 7 = pin-protect enable, and bits 6..4 = 0. It reads 0xFF during a program cycle. It repeats for as long as CS stays low.
- R9: During a program cycle every command except the status read is ignored. A read leaves SO high-impedance, and a write changes nothing.
- R10: A commit starts a program cycle that lasts `PROG_CYCLES` clocks. A committed status write stores bits 7, 3 and 2 of its data byte.
- R11: `prot_level` and `prot_pin_en` always show the stored protect level and pin-protect enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data in |
| wr_permit | input | 1 | Protection decision for the pending commit, 1 = allowed |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` (0 = high impedance) |
| prot_level | output | 2 | Stored block-protect level |
| prot_pin_en | output | 1 | Stored pin-protect enable |

## Verification
The bench sweeps every command byte that falls outside the six valid encodings, including the ones that differ from a valid command only in the upper nibble. A decoder that masked too few bits would answer one of them on SO or change the latch. It writes 34 bytes into one page and reads the whole page back; an incrementer that carried into bit 5 would spill into the next page and leave the first two slots with their first values. It ends writes on a partial byte and with zero data bytes, and it withholds the latch and the permit. A design that committed early would show busy or corrupt the model. It reads across the 0x3FF boundary, and it issues reads and writes during a program cycle, where a design that failed to gate commands would drive SO or overwrite data.

// File: rtl/spi_nvm_pkg.sv
package spi_nvm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_READ,
        ST_WRITE,
        ST_STAT_RD,
        ST_STAT_WR,
        ST_SKIP
    } sp_state_e;

    localparam logic [2:0] CMD_WEL_SET = 3'b110;
    localparam logic [2:0] CMD_WEL_CLR = 3'b100;
    localparam logic [2:0] CMD_STAT_RD = 3'b101;
    localparam logic [2:0] CMD_STAT_WR = 3'b001;
    localparam logic [2:0] CMD_ARR_RD  = 3'b011;
    localparam logic [2:0] CMD_ARR_WR  = 3'b010;

endpackage

// File: rtl/spi_nvm_sync.sv
module spi_nvm_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
            else        chain <= {chain[STAGES-2:0], d[g]};
        end
        assign q[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/spi_nvm_timer.sv
module spi_nvm_timer #(
    parameter int PROG_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   remain <= '0;
        else if (start && remain == '0) remain <= CW'(PROG_CYCLES);
        else if (remain != '0)        remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);
    assign done = (remain == CW'(1));

    AST_TMR_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy); // R10
    AST_TMR_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R9

endmodule

// File: rtl/spi_nvm_array.sv
module spi_nvm_array #(
    parameter int MEM_BYTES  = 1024,
    parameter int PAGE_BYTES = 32
) (
    input  logic                        clk,
    input  logic [$clog2(MEM_BYTES)-1:0] rd_addr,
    output logic [7:0]                  rd_data,
    input  logic                        wr_en,
    input  logic [$clog2(MEM_BYTES)-$clog2(PAGE_BYTES)-1:0] wr_page,
    input  logic [PAGE_BYTES-1:0][7:0]  wr_data,
    input  logic [PAGE_BYTES-1:0]       wr_mask
);

    localparam int PW = $clog2(PAGE_BYTES);

    logic [7:0] mem [MEM_BYTES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int k = 0; k < PAGE_BYTES; k++) begin
                if (wr_mask[k]) mem[{wr_page, PW'(k)}] <= wr_data[k];
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/spi_nvm_ctrl.sv
module spi_nvm_ctrl
    import spi_nvm_pkg::*;
#(
    parameter int MEM_BYTES  = 1024,
    parameter int PAGE_BYTES = 32,
    parameter int ADDR_FIELD = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sck_s,
    input  logic                        si_s,
    input  logic                        cs_n_s,
    input  logic                        busy,
    input  logic                        done,
    input  logic                        wr_permit,
    output logic [$clog2(MEM_BYTES)-1:0] rd_addr,
    input  logic [7:0]                  rd_data,
    output logic                        arr_we,
    output logic [$clog2(MEM_BYTES)-$clog2(PAGE_BYTES)-1:0] arr_page,
    output logic [PAGE_BYTES-1:0][7:0]  arr_wdata,
    output logic [PAGE_BYTES-1:0]       arr_mask,
    output logic                        prog_start,
    output logic                        so,
    output logic                        so_oe,
    output logic [1:0]                  prot_level,
    output logic                        prot_pin_en
);

    localparam int AW  = $clog2(MEM_BYTES);
    localparam int PW  = $clog2(PAGE_BYTES);
    localparam int PGW = AW - PW;
    localparam int CW  = $clog2(ADDR_FIELD);

    sp_state_e state_q, state_d;

    logic           sck_d, cs_d;
    logic           sck_rise, sck_fall, cs_rise, cs_fall;
    logic [CW-1:0]  cnt;
    logic [6:0]     shin;
    logic [7:0]     rx_byte, outsh, status_byte;
    logic [AW-1:0]  addr_q, addr_full;
    logic           is_rd, wel, pin_en, sts_pin;
    logic [1:0]     lvl, sts_lvl;
    logic           byte_done, commit_ok, so_q, so_en;
    logic [PGW-1:0] page_q;
    logic [PW-1:0]  ptr_q;
    logic [PAGE_BYTES-1:0][7:0] pbuf;
    logic [PAGE_BYTES-1:0]      mask_q;

    function automatic sp_state_e opc_target(input logic [7:0] op, input logic bsy);
        if (op[7:4] != 4'h0) return ST_SKIP;
        if (bsy) return (op[2:0] == CMD_STAT_RD) ? ST_STAT_RD : ST_SKIP;
        case (op[2:0])
            CMD_STAT_RD:            return ST_STAT_RD;
            CMD_STAT_WR:            return ST_STAT_WR;
            CMD_ARR_RD, CMD_ARR_WR: return ST_ADDR;
            default:                return ST_SKIP;
        endcase
    endfunction

    assign sck_rise    = sck_s & ~sck_d;
    assign sck_fall    = ~sck_s & sck_d;
    assign cs_rise     = cs_n_s & ~cs_d;
    assign cs_fall     = ~cs_n_s & cs_d;
    assign rx_byte     = {shin, si_s};
    assign addr_full   = {addr_q[AW-2:0], si_s};
    assign rd_addr     = (state_q == ST_ADDR) ? addr_full : addr_q;
    assign status_byte = busy ? 8'hFF : {pin_en, 3'b000, lvl, wel, 1'b0};

    assign commit_ok  = cs_rise && byte_done && wel && wr_permit && !busy &&
                        (state_q == ST_WRITE || state_q == ST_STAT_WR);
    assign prog_start = commit_ok;
    assign arr_we     = commit_ok && (state_q == ST_WRITE);
    assign arr_page   = page_q;
    assign arr_wdata  = pbuf;
    assign arr_mask   = mask_q;

    always_comb begin
        state_d = state_q;
        if (cs_rise) begin
            state_d = ST_IDLE;
        end else if (cs_fall) begin
            state_d = ST_OPC;
        end else if (!cs_n_s && sck_rise) begin
            unique case (state_q)
                ST_OPC:  if (cnt[2:0] == 3'd7) state_d = opc_target(rx_byte, busy);
                ST_ADDR: if (cnt == CW'(ADDR_FIELD - 1)) state_d = is_rd ? ST_READ : ST_WRITE;
                ST_IDLE, ST_READ, ST_WRITE, ST_STAT_RD, ST_STAT_WR, ST_SKIP: ;
                default: state_d = ST_SKIP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d     <= 1'b0;
            cs_d      <= 1'b1;
            cnt       <= '0;
            shin      <= '0;
            outsh     <= '0;
            addr_q    <= '0;
            is_rd     <= 1'b0;
            wel       <= 1'b0;
            pin_en    <= 1'b0;
            lvl       <= '0;
            sts_pin   <= 1'b0;
            sts_lvl   <= '0;
            byte_done <= 1'b0;
            page_q    <= '0;
            ptr_q     <= '0;
            pbuf      <= '0;
            mask_q    <= '0;
            so_q      <= 1'b0;
            so_en     <= 1'b0;
        end else begin
            sck_d <= sck_s;
            cs_d  <= cs_n_s;
            if (done) wel <= 1'b0;
            if (cs_fall) begin
                cnt       <= '0;
                so_en     <= 1'b0;
                byte_done <= 1'b0;
            end else if (cs_rise) begin
                so_en <= 1'b0;
                if (commit_ok && state_q == ST_STAT_WR) begin
                    pin_en <= sts_pin;
                    lvl    <= sts_lvl;
                end
            end else if (!cs_n_s && sck_rise) begin
                shin <= rx_byte[6:0];
                cnt  <= cnt + 1'b1;
                unique case (state_q)
                    ST_OPC: begin
                        if (cnt[2:0] == 3'd7) begin
                            cnt <= '0;
                            if (rx_byte[7:4] == 4'h0 && !busy) begin
                                case (rx_byte[2:0])
                                    CMD_WEL_SET: wel   <= 1'b1;
                                    CMD_WEL_CLR: wel   <= 1'b0;
                                    CMD_ARR_RD:  is_rd <= 1'b1;
                                    CMD_ARR_WR:  is_rd <= 1'b0;
                                    default: ;
                                endcase
                            end
                            outsh <= status_byte;
                        end
                    end
                    ST_ADDR: begin
                        addr_q <= addr_full;
                        if (cnt == CW'(ADDR_FIELD - 1)) begin
                            if (is_rd) begin
                                outsh  <= rd_data;
                                addr_q <= addr_full + 1'b1;
                            end else begin
                                page_q    <= addr_full[AW-1:PW];
                                ptr_q     <= addr_full[PW-1:0];
                                mask_q    <= '0;
                                byte_done <= 1'b0;
                            end
                        end
                    end
                    ST_READ: begin
                        if (cnt[2:0] == 3'd7) begin
                            outsh  <= rd_data;
                            addr_q <= addr_q + 1'b1;
                        end
                    end
                    ST_STAT_RD: begin
                        if (cnt[2:0] == 3'd7) outsh <= status_byte;
                    end
                    ST_WRITE: begin
                        if (cnt[2:0] == 3'd7) begin
                            pbuf[ptr_q]   <= rx_byte;
                            mask_q[ptr_q] <= 1'b1;
                            ptr_q         <= ptr_q + 1'b1;
                            byte_done     <= 1'b1;
                        end else begin
                            byte_done <= 1'b0;
                        end
                    end
                    ST_STAT_WR: begin
                        if (cnt[2:0] == 3'd7) begin
                            sts_pin   <= rx_byte[7];
                            sts_lvl   <= rx_byte[3:2];
                            byte_done <= 1'b1;
                        end else begin
                            byte_done <= 1'b0;
                        end
                    end
                    ST_IDLE, ST_SKIP: ;
                    default: ;
                endcase
            end else if (!cs_n_s && sck_fall &&
                         (state_q == ST_READ || state_q == ST_STAT_RD)) begin
                so_q  <= outsh[7];
                outsh <= {outsh[6:0], 1'b0};
                so_en <= 1'b1;
            end
        end
    end

    assign so          = so_q;
    assign so_oe       = so_en;
    assign prot_level  = lvl;
    assign prot_pin_en = pin_en;

    AST_SO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && $past(so_oe) && !$past(sck_fall)) |-> $stable(so)); // R1
    AST_HIZ_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_s) |=> !so_oe); // R3
    AST_SKIP_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP) |-> !so_oe); // R3
    AST_WEL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !wel); // R4
    AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE && $past(state_q == ST_WRITE)) |-> $stable(page_q)); // R6
    AST_BUSY_STATES: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(state_q inside {ST_ADDR, ST_READ, ST_WRITE, ST_STAT_WR})); // R9

endmodule

// File: rtl/spi_nvm_slave.sv
module spi_nvm_slave #(
    parameter int MEM_BYTES   = 1024,
    parameter int PAGE_BYTES  = 32,
    parameter int PROG_CYCLES = 5000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       si,
    input  logic       wr_permit,
    output logic       so,
    output logic       so_oe,
    output logic [1:0] prot_level,
    output logic       prot_pin_en
);

    localparam int AW  = $clog2(MEM_BYTES);
    localparam int PGW = AW - $clog2(PAGE_BYTES);

    logic [2:0]     sync_q;
    logic           busy, done, prog_start, arr_we;
    logic [AW-1:0]  rd_addr;
    logic [7:0]     rd_data;
    logic [PGW-1:0] arr_page;
    logic [PAGE_BYTES-1:0][7:0] arr_wdata;
    logic [PAGE_BYTES-1:0]      arr_mask;

    spi_nvm_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, sck, si}), .q(sync_q)
    );

    spi_nvm_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(busy), .done(done)
    );

    spi_nvm_array #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_array (
        .clk(clk), .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(arr_we),
        .wr_page(arr_page), .wr_data(arr_wdata), .wr_mask(arr_mask)
    );

    spi_nvm_ctrl #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .ADDR_FIELD(16)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .sck_s(sync_q[1]), .si_s(sync_q[0]), .cs_n_s(sync_q[2]),
        .busy(busy), .done(done), .wr_permit(wr_permit),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .arr_we(arr_we), .arr_page(arr_page), .arr_wdata(arr_wdata), .arr_mask(arr_mask),
        .prog_start(prog_start), .so(so), .so_oe(so_oe),
        .prot_level(prot_level), .prot_pin_en(prot_pin_en)
    );

endmodule

// File: tb/spi_nvm_slave_bench.sv
module spi_nvm_slave_bench;

    localparam int H    = 6;
    localparam int PROG = 3000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, wr_permit = 1'b1;
    logic so, so_oe, prot_pin_en;
    logic [1:0] prot_level;

    int n_chk = 0, n_fail = 0;
    bit mode3 = 1'b0;
    bit finished = 1'b0;
    logic [7:0] model [1024];
    logic [7:0] rx, st, op8;
    int oe1, oe2;
    bit valid;

    always #5 clk = ~clk;

    spi_nvm_slave #(.PROG_CYCLES(PROG)) u_spi_nvm_slave (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .wr_permit(wr_permit), .so(so), .so_oe(so_oe),
        .prot_level(prot_level), .prot_pin_en(prot_pin_en)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cs_start();
        sck = mode3;
        tick(H);
        cs_n = 1'b0;
        tick(H);
    endtask

    task automatic cs_stop();
        if (!mode3) begin
            sck = 1'b0;
            tick(H);
        end
        cs_n = 1'b1;
        tick(2 * H);
    endtask

    task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rxb, output int oe);
        oe = 0;
        rxb = '0;
        for (int b = 7; b > 7 - nb; b--) begin
            sck = 1'b0;
            si = tx[b];
            tick(H);
            rxb[b] = so;
            oe += int'(so_oe);
            sck = 1'b1;
            tick(H);
        end
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rxb, output int oe);
        xbits(tx, 8, rxb, oe);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        int o;
        cs_start();
        xbyte(op, r, o);
        cs_stop();
    endtask

    task automatic rd_status(output logic [7:0] s, output int oe);
        logic [7:0] r;
        int o;
        cs_start();
        xbyte(8'h05, r, o);
        xbyte(8'h00, s, oe);
        cs_stop();
    endtask

    task automatic wait_ready(output logic [7:0] s);
        int o;
        for (int i = 0; i < 100; i++) begin
            rd_status(s, o);
            if (s != 8'hFF) break;
        end
    endtask

    task automatic wr_bytes(input logic [15:0] a, input int n, input logic [7:0] seed,
                            input logic [7:0] mul, input bit expect_commit);
        logic [7:0] r, d;
        int o;
        int base, off;
        cs_start();
        xbyte(8'h02, r, o);
        xbyte(a[15:8], r, o);
        xbyte(a[7:0], r, o);
        base = int'(a[9:0]) & ~31;
        for (int k = 0; k < n; k++) begin
            d = seed + 8'(k) * mul;
            xbyte(d, r, o);
            off = (int'(a[9:0]) + k) & 31;
            if (expect_commit) model[base | off] = d;
        end
        cs_stop();
    endtask

    task automatic rd_chk(input logic [15:0] a, input int n, input string req);
        logic [7:0] r;
        int o;
        int ea;
        cs_start();
        xbyte(8'h03, r, o);
        xbyte(a[15:8], r, o);
        xbyte(a[7:0], r, o);
        for (int i = 0; i < n; i++) begin
            xbyte(8'h00, r, o);
            ea = (int'(a[9:0]) + i) & 1023;
            chk(r == model[ea] && o == 8, req, int'(r), int'(model[ea]));
        end
        cs_stop();
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(4);

        // Reset state
        chk(so_oe == 1'b0, "R3 reset SO hi-z", int'(so_oe), 0);
        chk(prot_level == 2'd0 && prot_pin_en == 1'b0, "R11 reset protect outputs",
            int'({prot_pin_en, prot_level}), 0);
        rd_status(st, oe1);
        chk(st == 8'h00, "R4 R8 status after reset", int'(st), 8'h00);
        chk(oe1 == 8, "R1 status driven on SO", oe1, 8);

        // Command decoding, bit 3 ignored
        cmd1(8'h06);
        rd_status(st, oe1);
        chk(st == 8'h02, "R2 R4 latch set", int'(st), 8'h02);
        cmd1(8'h0C);
        rd_status(st, oe1);
        chk(st == 8'h00, "R2 R4 latch clear with bit3 set", int'(st), 8'h00);
        cmd1(8'h0E);
        rd_status(st, oe1);
        chk(st == 8'h02, "R2 latch set with bit3 set", int'(st), 8'h02);

        // Every invalid command byte: no SO, no effect
        for (int op = 0; op < 256; op++) begin
            op8 = 8'(op);
            valid = (op8[7:4] == 4'h0) && (op8[2:0] != 3'd0) && (op8[2:0] != 3'd7);
            if (!valid) begin
                cs_start();
                xbyte(op8, rx, oe1);
                xbyte(8'h05, rx, oe2);
                cs_stop();
                chk(oe1 + oe2 == 0, "R3 invalid command leaves SO hi-z", oe1 + oe2, 0);
            end
        end
        rd_status(st, oe1);
        chk(st == 8'h02, "R2 R3 invalid commands left latch", int'(st), 8'h02);

        // Simple write, then commands during the program cycle
        wr_bytes(16'h0100, 1, 8'h11, 8'h00, 1'b1);
        wait_ready(st);
        chk(st == 8'h00, "R4 latch cleared at end of program", int'(st), 8'h00);
        cmd1(8'h06);
        wr_bytes(16'h0040, 3, 8'hA0, 8'h05, 1'b1);
        rd_status(st, oe1);
        chk(st == 8'hFF, "R8 R10 status all ones while busy", int'(st), 8'hFF);
        cs_start();
        xbyte(8'h03, rx, oe1);
        xbyte(8'h00, rx, oe1);
        xbyte(8'h40, rx, oe1);
        xbyte(8'h00, rx, oe2);
        cs_stop();
        chk(oe2 == 0, "R9 read ignored while busy", oe2, 0);
        wr_bytes(16'h0100, 1, 8'h77, 8'h00, 1'b0);
        wait_ready(st);
        chk(st == 8'h00, "R4 R9 latch clear after busy", int'(st), 8'h00);
        rd_chk(16'h0100, 1, "R9 write during busy ignored");
        rd_chk(16'h0040, 3, "R5 R7 byte write readback");

        // Mode 3: page wrap and read wrap
        mode3 = 1'b1;
        cmd1(8'h06);
        wr_bytes(16'h007E, 34, 8'h03, 8'h07, 1'b1);
        wait_ready(st);
        rd_chk(16'h0060, 32, "R6 page wrap contents");
        cmd1(8'h06);
        wr_bytes(16'h03FC, 4, 8'hC1, 8'h11, 1'b1);
        wait_ready(st);
        cmd1(8'h06);
        wr_bytes(16'h0000, 2, 8'h5A, 8'h33, 1'b1);
        wait_ready(st);
        rd_chk(16'h03FC, 6, "R5 R1 read wraps to zero");
        rd_chk(16'hA060, 2, "R5 upper address bits ignored");
        mode3 = 1'b0;

        // Abort on partial byte and on zero data bytes
        cmd1(8'h06);
        cs_start();
        xbyte(8'h02, rx, oe1);
        xbyte(8'h00, rx, oe1);
        xbyte(8'h60, rx, oe1);
        xbyte(8'hEE, rx, oe1);
        xbits(8'hFF, 3, rx, oe1);
        cs_stop();
        rd_status(st, oe1);
        chk(st == 8'h02, "R7 partial byte no commit", int'(st), 8'h02);
        rd_chk(16'h0060, 1, "R7 partial byte array unchanged");
        cs_start();
        xbyte(8'h02, rx, oe1);
        xbyte(8'h00, rx, oe1);
        xbyte(8'h60, rx, oe1);
        cs_stop();
        rd_status(st, oe1);
        chk(st == 8'h02, "R7 no data bytes no commit", int'(st), 8'h02);

        // Latch clear and permit low
        cmd1(8'h04);
        wr_bytes(16'h0060, 1, 8'h99, 8'h00, 1'b0);
        rd_status(st, oe1);
        chk(st == 8'h00, "R7 no latch no commit", int'(st), 8'h00);
        rd_chk(16'h0060, 1, "R7 no latch array unchanged");
        cmd1(8'h06);
        wr_permit = 1'b0;
        wr_bytes(16'h0060, 1, 8'h99, 8'h00, 1'b0);
        rd_status(st, oe1);
        chk(st == 8'h02, "R7 permit low no commit", int'(st), 8'h02);
        rd_chk(16'h0060, 1, "R7 permit low array unchanged");
        cs_start();
        xbyte(8'h01, rx, oe1);
        xbyte(8'hFF, rx, oe1);
        cs_stop();
        chk(prot_level == 2'd0 && prot_pin_en == 1'b0, "R7 status write blocked",
            int'({prot_pin_en, prot_level}), 0);
        wr_permit = 1'b1;

        // Status write
        cs_start();
        xbyte(8'h09, rx, oe1);
        xbyte(8'hFF, rx, oe1);
        cs_stop();
        rd_status(st, oe1);
        chk(st == 8'hFF, "R8 status busy after status write", int'(st), 8'hFF);
        wait_ready(st);
        chk(st == 8'h8C, "R8 R10 stored status fields", int'(st), 8'h8C);
        chk(prot_level == 2'd3 && prot_pin_en == 1'b1, "R11 protect outputs",
            int'({prot_pin_en, prot_level}), 7);
        cmd1(8'h06);
        cs_start();
        xbyte(8'h01, rx, oe1);
        xbyte(8'h04, rx, oe1);
        cs_stop();
        wait_ready(st);
        chk(st == 8'h04, "R10 level one stored", int'(st), 8'h04);
        chk(prot_level == 2'd1 && prot_pin_en == 1'b0, "R11 protect outputs level one",
            int'({prot_pin_en, prot_level}), 1);

        // Status repeats while selected
        cmd1(8'h06);
        cs_start();
        xbyte(8'h05, rx, oe1);
        for (int i = 0; i < 3; i++) begin
            xbyte(8'h00, rx, oe1);
            chk(rx == 8'h06 && oe1 == 8, "R8 status repeats", int'(rx), 8'h06);
        end
        cs_stop();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule